// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Idle and Break Frames

This block sends one asynchronous serial frame per accepted request. A request carries a frame kind (data, idle or break), a data word, a word-length select, a parity enable with an even/odd choice and a 16-bit baud divisor. A data frame has a low start bit, 8 or 9 data bits sent least significant bit first and a high stop bit. When parity is enabled, the last data position carries a parity bit instead of the top data bit.

An idle frame keeps the line high for one whole frame length, including the start position. A break frame drives the line low for one whole frame length and then sends one extra high bit. The transmitter has its own bit-rate counter. That counter reloads from the divisor latched when the request is accepted, so one bit lasts divisor+1 clocks. The line stays high between frames. `tx_done` pulses for one clock when a frame ends.

Top module: `sertx_top`

## Requirements
- R1: After synchronous reset, `txd` is 1, `busy` is 0 and `tx_done` is 0.
- R2: A request (`req_valid`=1) is accepted only on a clock edge where `busy` is 0. Requests made while `busy` is 1 are ignored: they do not change the frame on the line and do not add a frame.
- R3: Each bit lasts `baud_div`+1 clocks. The first bit appears on `txd` in the cycle after the accepting edge.
- R4: Kind 2'b00 (or 2'b11) sends a data frame: a start bit of 0, then the data bits least significant bit first, then a stop bit of 1. With `word9`=0 the data bits are `req_data[7:0]` (10 bits in total). With `word9`=1 they are `req_data[8:0]` (11 bits in total).
- R5: With `par_en`=1, the last data position (bit 7 in 8-bit mode, bit 8 in 9-bit mode) carries parity instead of data. Parity is the XOR of the data bits below that position, inverted when `par_odd`=1.
- R6: Kind 2'b01 sends an idle frame: `txd` stays 1 for as many bit periods as a data frame in the selected word length.
- R7: Kind 2'b10 sends a break frame: `txd` is 0 for as many bit periods as a data frame in the selected word length, followed by one extra bit period of 1.
- R8: `busy` stays 1 for exactly (frame bits × (`baud_div`+1)) clocks. `tx_done` is 1 for exactly the one clock in which `busy` has just fallen.
- R9: `txd` is 1 whenever `busy` is 0.
- R10: `word9`, `par_en`, `par_odd`, `req_kind`, `req_data` and `baud_div` are sampled at acceptance. Changing them during a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Frame request |
| req_kind | input | 2 | 00 data, 01 idle, 10 break, 11 data |
| req_data | input | 9 | Data word; bit 8 is used only in 9-bit mode |
| word9 | input | 1 | 1 selects the 9-bit word length |
| par_en | input | 1 | Parity enable |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| baud_div | input | 16 | Bit period minus one, in clocks |
| txd | output | 1 | Serial line |
| busy | output | 1 | A frame is in progress |
| tx_done | output | 1 | One-clock end-of-frame pulse |

## Verification
The hardest case to reach is a request, together with new configuration values, that arrives in the middle of a frame. A correct design must ignore the request and also keep the latched divisor and word length. The stimulus holds `req_valid` high from the second cycle of some frames until the end cycle. During that window it changes `baud_div`, the kind and the word length, and drops the request just before the first idle edge. The bench then compares every cycle of the line with the frame that was first requested, and checks that `tx_done` pulses only once. Zero divisors, break frames in both word lengths and both parity polarities are also forced directly.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int DATA_MAX_DEF = 9;
    localparam int DIV_W_DEF    = 16;

    typedef enum logic [1:0] {
        KIND_DATA  = 2'b00,
        KIND_IDLE  = 2'b01,
        KIND_BREAK = 2'b10,
        KIND_ALT   = 2'b11
    } frame_kind_e;

    // Bits that precede the extra closing bit: start + data + stop
    function automatic int base_bits(input logic long_word, input int data_max);
        return (long_word ? data_max : data_max - 1) + 2;
    endfunction

endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DIV_W-1:0] div,
    input  logic             run,
    output logic             tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            div_q <= '0;
        end else if (load) begin
            cnt   <= div;
            div_q <= div;
        end else if (run) begin
            if (cnt == '0) cnt <= div_q;
            else           cnt <= cnt - 1'b1;
        end
    end

    assign tick = run && (cnt == '0);

    // R3: the counter never exceeds the latched reload value
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= div_q));

    // R10: the latched divisor only changes on a load
    p_div_held_r10: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(div_q));

endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
    import sertx_pkg::*;
#(
    parameter int DATA_MAX = 9,
    parameter int FRAME_W  = DATA_MAX + 3,
    parameter int CNT_W    = $clog2(FRAME_W + 1)
) (
    input  logic [1:0]          kind,
    input  logic [DATA_MAX-1:0] data,
    input  logic                long_word,
    input  logic                par_en,
    input  logic                par_odd,
    output logic [FRAME_W-1:0]  bits,
    output logic [CNT_W-1:0]    nbits
);
    int  dw;
    int  nb;
    logic par;

    always_comb begin
        dw   = long_word ? DATA_MAX : DATA_MAX - 1;
        nb   = base_bits(long_word, DATA_MAX);
        bits = '1;
        par  = par_odd;
        nbits = CNT_W'(nb);
        case (frame_kind_e'(kind))
            KIND_IDLE: begin
                bits = '1;
            end
            KIND_BREAK: begin
                for (int i = 0; i < FRAME_W; i++)
                    bits[i] = (i < nb) ? 1'b0 : 1'b1;
                nbits = CNT_W'(nb + 1);
            end
            default: begin
                bits[0] = 1'b0;
                for (int i = 0; i < DATA_MAX; i++) begin
                    if (i < dw)     bits[i+1] = data[i];
                    if (i < dw - 1) par = par ^ data[i];
                end
                if (par_en) bits[dw] = par;
                bits[dw+1] = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
    parameter int FRAME_W = 12,
    parameter int CNT_W   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req,
    input  logic [FRAME_W-1:0] bits,
    input  logic [CNT_W-1:0]   nbits,
    input  logic               tick,
    output logic               accept,
    output logic               txd,
    output logic               busy,
    output logic               done
);
    logic [FRAME_W-1:0] shreg;
    logic [CNT_W-1:0]   remain;

    assign accept = req && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg  <= '1;
            remain <= '0;
            busy   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                shreg  <= bits;
                remain <= nbits;
                busy   <= 1'b1;
            end else if (busy && tick) begin
                if (remain == CNT_W'(1)) begin
                    shreg  <= '1;
                    remain <= '0;
                    busy   <= 1'b0;
                    done   <= 1'b1;
                end else begin
                    shreg  <= {1'b1, shreg[FRAME_W-1:1]};
                    remain <= remain - 1'b1;
                end
            end
        end
    end

    assign txd = shreg[0];

    // R9: line is high whenever no frame is running
    p_line_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !busy |-> txd);

    // R8: completion pulse lasts one clock
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: completion coincides with busy having just fallen
    p_done_on_fall_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    // R3: the line only moves on a bit tick
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (busy && !tick) |=> $stable(txd));

    // R2: a request during a frame does not disturb the shift register
    p_ignore_r2: assert property (@(posedge clk) disable iff (rst)
        (busy && req && !tick) |=> $stable(shreg));

endmodule

// File: rtl/sertx_top.sv
module sertx_top
    import sertx_pkg::*;
#(
    parameter int DATA_MAX = DATA_MAX_DEF,
    parameter int DIV_W    = DIV_W_DEF
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  logic [1:0]          req_kind,
    input  logic [DATA_MAX-1:0] req_data,
    input  logic                word9,
    input  logic                par_en,
    input  logic                par_odd,
    input  logic [DIV_W-1:0]    baud_div,
    output logic                txd,
    output logic                busy,
    output logic                tx_done
);
    localparam int FRAME_W = DATA_MAX + 3;
    localparam int CNT_W   = $clog2(FRAME_W + 1);

    logic [FRAME_W-1:0] frame_bits;
    logic [CNT_W-1:0]   frame_len;
    logic               tick;
    logic               accept;

    sertx_framer #(
        .DATA_MAX (DATA_MAX),
        .FRAME_W  (FRAME_W),
        .CNT_W    (CNT_W)
    ) u_framer (
        .kind      (req_kind),
        .data      (req_data),
        .long_word (word9),
        .par_en    (par_en),
        .par_odd   (par_odd),
        .bits      (frame_bits),
        .nbits     (frame_len)
    );

    sertx_baud #(
        .DIV_W (DIV_W)
    ) u_baud (
        .clk  (clk),
        .rst  (rst),
        .load (accept),
        .div  (baud_div),
        .run  (busy),
        .tick (tick)
    );

    sertx_shifter #(
        .FRAME_W (FRAME_W),
        .CNT_W   (CNT_W)
    ) u_shift (
        .clk    (clk),
        .rst    (rst),
        .req    (req_valid),
        .bits   (frame_bits),
        .nbits  (frame_len),
        .tick   (tick),
        .accept (accept),
        .txd    (txd),
        .busy   (busy),
        .done   (tx_done)
    );

    // R4: a data frame begins with a low start bit
    p_start_low_r4: assert property (@(posedge clk) disable iff (rst)
        (accept && (req_kind == 2'b00)) |=> !txd);

    // R7: a break frame begins low
    p_break_low_r7: assert property (@(posedge clk) disable iff (rst)
        (accept && (req_kind == 2'b10)) |=> !txd);

    // R6: an idle frame begins high
    p_idle_high_r6: assert property (@(posedge clk) disable iff (rst)
        (accept && (req_kind == 2'b01)) |=> txd);

endmodule

// File: tb/tb_sertx_top.sv
module tb_sertx_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [1:0]  req_kind;
    logic [8:0]  req_data;
    logic        word9, par_en, par_odd;
    logic [15:0] baud_div;
    logic        txd, busy, tx_done;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    sertx_top dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_data(req_data), .word9(word9), .par_en(par_en), .par_odd(par_odd),
        .baud_div(baud_div), .txd(txd), .busy(busy), .tx_done(tx_done)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] model(input logic [1:0] k, input logic [8:0] d,
                                          input logic w9, input logic pe, input logic po,
                                          output int len);
        logic [11:0] v;
        int nd;
        logic p;
        nd = w9 ? 9 : 8;
        v = '1;
        len = nd + 2;
        if (k == 2'b01) begin
            v = '1;
        end else if (k == 2'b10) begin
            for (int i = 0; i < nd + 2; i++) v[i] = 1'b0;
            len = nd + 3;
        end else begin
            v[0] = 1'b0;
            for (int i = 0; i < nd; i++) v[i+1] = d[i];
            if (pe) begin
                p = po;
                for (int i = 0; i < nd - 1; i++) p = p ^ d[i];
                v[nd] = p;
            end
            v[nd+1] = 1'b1;
        end
        return v;
    endfunction

    task automatic send(input logic [1:0] k, input logic [8:0] d, input logic w9,
                        input logic pe, input logic po, input logic [15:0] dv,
                        input logic disturb);
        logic [11:0] exp;
        int len, per, bad, badk, dones;
        exp = model(k, d, w9, pe, po, len);
        per = int'(dv) + 1;
        bad = 0; badk = -1; dones = 0;
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_data = d;
        word9 = w9; par_en = pe; par_odd = po; baud_div = dv;
        @(negedge clk);
        req_valid = 1'b0;
        for (int c = 0; c < len * per; c++) begin
            if (txd !== exp[c / per] || busy !== 1'b1) begin
                bad++;
                if (badk < 0) badk = c;
            end
            if (tx_done) dones++;
            if (disturb && c == 1) begin
                req_valid = 1'b1;
                req_kind = ~k;
                req_data = ~d;
                word9 = ~w9;
                par_odd = ~po;
                baud_div = dv + 16'd3;
            end
            @(negedge clk);
        end
        // R3 R4 R5 R6 R7 R10 R2: every cycle of the frame matches the first request
        check(bad == 0 && dones == 0, "R3/R4/R5/R6/R7 waveform R10 R2", badk, -1);
        // R8 R9: frame end
        check(busy == 1'b0 && tx_done == 1'b1 && txd == 1'b1, "R8 end pulse R9 line high",
              {busy, tx_done, txd}, 3);
        req_valid = 1'b0;
        baud_div = dv;
        @(negedge clk);
        check(tx_done == 1'b0 && txd == 1'b1 && busy == 1'b0, "R8 single pulse R9",
              {busy, tx_done, txd}, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        rst = 1'b1; req_valid = 1'b0; req_kind = 2'b00; req_data = '0;
        word9 = 1'b0; par_en = 1'b0; par_odd = 1'b0; baud_div = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(txd == 1'b1 && busy == 1'b0 && tx_done == 1'b0, "R1 reset",
              {txd, busy, tx_done}, 4);
        rst = 1'b0;
        @(negedge clk);
        // Directed corners
        send(2'b00, 9'h0A5, 1'b0, 1'b0, 1'b0, 16'd0, 1'b0); // R4 8-bit, div 0
        send(2'b00, 9'h1C3, 1'b1, 1'b0, 1'b0, 16'd2, 1'b0); // R4 9-bit
        send(2'b00, 9'h07F, 1'b0, 1'b1, 1'b0, 16'd1, 1'b0); // R5 even
        send(2'b00, 9'h07F, 1'b0, 1'b1, 1'b1, 16'd1, 1'b0); // R5 odd
        send(2'b00, 9'h1FF, 1'b1, 1'b1, 1'b1, 16'd0, 1'b0); // R5 9-bit odd
        send(2'b01, 9'h000, 1'b0, 1'b0, 1'b0, 16'd3, 1'b0); // R6
        send(2'b01, 9'h000, 1'b1, 1'b0, 1'b0, 16'd0, 1'b0); // R6 9-bit
        send(2'b10, 9'h1FF, 1'b0, 1'b0, 1'b0, 16'd2, 1'b0); // R7 8-bit
        send(2'b10, 9'h000, 1'b1, 1'b0, 1'b0, 16'd0, 1'b0); // R7 9-bit
        send(2'b10, 9'h055, 1'b0, 1'b1, 1'b0, 16'd4, 1'b1); // R2 R10 disturbed break
        send(2'b00, 9'h133, 1'b1, 1'b1, 1'b0, 16'd5, 1'b1); // R2 R10 disturbed data
        send(2'b11, 9'h0E1, 1'b0, 1'b0, 1'b1, 16'd1, 1'b0); // R4 kind 11
        // Random frames
        for (int n = 0; n < 120; n++) begin
            send(2'($urandom % 4), 9'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), 16'($urandom % 8), 1'($urandom % 3 == 0));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule